// File: doc/BRIEF.md
# Program Memory Fetch Source Mapper

This block decides, for every code fetch and every table read (MOVC) issued by an 8-bit controller core, which program store delivers the byte: internal volatile code RAM, internal boot ROM, or the external program bus. The decision is purely combinational from the fetch address and a few latched controls, so a region select is valid in the same cycle as the address. The block drives one select strobe per region, an enable for the external program read strobe, and the reset vector the core loads when it leaves reset.

An external-access strap is captured only while reset is held. With the strap low, the whole code space is external and execution starts at 0000h. With the strap high, the lower half is code RAM and the upper half is boot ROM or external memory, depending on a boot-enable bit that reset sets to 1. Execution then starts at F800h. A security setting stops a table read issued by code running from external memory from seeing internal bytes. Such a read returns 00h and sets a sticky violation flag.

Top module: `pmem_fetch_map`

## Requirements
- R1: With the strap captured low, every valid fetch asserts only the external select and the external strobe enable, and the reset vector is 0000h.
- R2: With the strap captured high, a valid fetch at 0000h..7FFFh asserts only the code-RAM select, and the external strobe enable stays low.
- R3: With the strap high and boot-enable at 1, a valid fetch at 8000h..FFFFh asserts only the boot-ROM select, and the external strobe enable stays low.
- R4: With the strap high and boot-enable at 0, a valid fetch at 8000h..FFFFh asserts only the external select and the external strobe enable.
- R5: Boot-enable reads 1 after reset. A cycle with the write strobe high loads the write data bit on the next clock edge.
- R6: With the strap captured high, the reset vector is F800h.
- R7: The strap is sampled only while reset is active. Strap changes after reset leave the reset vector and the decode unchanged.
- R8: At most one region select is high at any time, and none is high while fetch-valid is low.
- R9: With the security-level-2 input high, a MOVC (isMovc=1) issued with execFromInternal=0 that targets code RAM or boot ROM asserts no select and returns 00h.
- R10: A blocked read sets the violation flag on the next clock edge. The flag stays set until reset.
- R11: When a read is not blocked, the read data equals the byte of the selected source (RAM, ROM or external input), and it is 00h when no select is high.
- R12: Selects and read data follow the address in the same cycle, with no clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; the strap is sampled while it is low |
| extAccessStrap | input | 1 | External-access strap (0 = all code external) |
| bootEnWr | input | 1 | Write strobe for the boot-enable bit |
| bootEnWrData | input | 1 | Value written to boot-enable |
| secLevel2 | input | 1 | Security level 2 active |
| fetchValid | input | 1 | A fetch or table read is in progress |
| fetchAddr | input | 16 | Code address |
| isMovc | input | 1 | The access is a table read, not an opcode fetch |
| execFromInternal | input | 1 | The current instruction runs from internal memory |
| ramData | input | 8 | Byte from code RAM |
| romData | input | 8 | Byte from boot ROM |
| extData | input | 8 | Byte from external program bus |
| selCodeRam | output | 1 | Code-RAM select |
| selBootRom | output | 1 | Boot-ROM select |
| selExternal | output | 1 | External program memory select |
| extStrobeEn | output | 1 | Enable for the external program read strobe and the bus ports |
| resetVector | output | 16 | Start address after reset |
| readData | output | 8 | Byte returned to the core |
| bootEnable | output | 1 | Current boot-enable bit |
| movcViolation | output | 1 | Sticky flag for a blocked table read |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit byte and a boot vector of F800h. This puts the split at the exact 7FFFh/8000h boundary and the top address FFFFh within reach of directed addresses. Separate reset runs with the strap low and high cover both captured strap states. Strap toggling after reset, boot-enable writes, and table reads with each combination of security setting and execution source cover the blocking path and the sticky flag.

// File: rtl/pmem_fetch_pkg.sv
package pmem_fetch_pkg;
  typedef struct packed {
    logic selRam;
    logic selRom;
    logic selExt;
    logic blocked;
  } fetchStrobes_t;
endpackage

// File: rtl/pmem_fetch_ctrl.sv
module pmem_fetch_ctrl
  import pmem_fetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BOOT_VEC = 16'hF800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extAccessStrap,
  input  logic              bootEnWr,
  input  logic              bootEnWrData,
  input  logic              secLevel2,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              isMovc,
  input  logic              execFromInternal,
  output fetchStrobes_t     strobes,
  output logic [ADDR_W-1:0] resetVector,
  output logic              bootEnable,
  output logic              movcViolation
);
  localparam int TOP_BIT = ADDR_W - 1;

  logic strapQ;
  logic bootEnQ;
  logic violQ;
  logic upperHalf;
  logic wantRam, wantRom, wantExt;
  logic blockNow;

  // Strap capture, boot-enable and sticky violation flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      strapQ  <= extAccessStrap;
      bootEnQ <= 1'b1;
      violQ   <= 1'b0;
    end else begin
      if (bootEnWr) bootEnQ <= bootEnWrData;
      if (blockNow) violQ <= 1'b1;
    end
  end

  // Region decode: purely combinational
  always_comb begin
    upperHalf = fetchAddr[TOP_BIT];
    wantExt   = fetchValid & (~strapQ | (upperHalf & ~bootEnQ));
    wantRam   = fetchValid & strapQ & ~upperHalf;
    wantRom   = fetchValid & strapQ & upperHalf & bootEnQ;
    blockNow  = (wantRam | wantRom) & isMovc & secLevel2 & ~execFromInternal;
    strobes.selRam  = wantRam & ~blockNow;
    strobes.selRom  = wantRom & ~blockNow;
    strobes.selExt  = wantExt;
    strobes.blocked = blockNow;
  end

  assign resetVector   = strapQ ? BOOT_VEC : '0;
  assign bootEnable    = bootEnQ;
  assign movcViolation = violQ;

  p_one_region_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selRam, strobes.selRom, strobes.selExt}));
  p_idle_no_select_r8: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> !(strobes.selRam | strobes.selRom | strobes.selExt));
  p_strap_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(strapQ));
  p_viol_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(violQ) |-> violQ);
  p_block_sets_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    blockNow |=> violQ);
  p_block_no_internal_r9: assert property (@(posedge clk) disable iff (!rstN)
    (isMovc && secLevel2 && !execFromInternal) |-> !(strobes.selRam | strobes.selRom));
endmodule

// File: rtl/pmem_fetch_dpath.sv
module pmem_fetch_dpath
  import pmem_fetch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  fetchStrobes_t     strobes,
  input  logic [DATA_W-1:0] ramData,
  input  logic [DATA_W-1:0] romData,
  input  logic [DATA_W-1:0] extData,
  output logic              extStrobeEn,
  output logic [DATA_W-1:0] readData
);
  always_comb begin
    readData = '0;
    if (!strobes.blocked) begin
      unique case (1'b1)
        strobes.selRam: readData = ramData;
        strobes.selRom: readData = romData;
        strobes.selExt: readData = extData;
        default:        readData = '0;
      endcase
    end
  end

  assign extStrobeEn = strobes.selExt;

  always_comb begin
    if (strobes.blocked) a_blocked_zero_r9: assert (readData == '0);
  end
endmodule

// File: rtl/pmem_fetch_map.sv
module pmem_fetch_map
  import pmem_fetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BOOT_VEC = 16'hF800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extAccessStrap,
  input  logic              bootEnWr,
  input  logic              bootEnWrData,
  input  logic              secLevel2,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              isMovc,
  input  logic              execFromInternal,
  input  logic [DATA_W-1:0] ramData,
  input  logic [DATA_W-1:0] romData,
  input  logic [DATA_W-1:0] extData,
  output logic              selCodeRam,
  output logic              selBootRom,
  output logic              selExternal,
  output logic              extStrobeEn,
  output logic [ADDR_W-1:0] resetVector,
  output logic [DATA_W-1:0] readData,
  output logic              bootEnable,
  output logic              movcViolation
);
  fetchStrobes_t strobes;

  pmem_fetch_ctrl #(.ADDR_W(ADDR_W), .BOOT_VEC(BOOT_VEC)) u_ctrl (
    .clk(clk), .rstN(rstN), .extAccessStrap(extAccessStrap),
    .bootEnWr(bootEnWr), .bootEnWrData(bootEnWrData), .secLevel2(secLevel2),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .isMovc(isMovc),
    .execFromInternal(execFromInternal), .strobes(strobes),
    .resetVector(resetVector), .bootEnable(bootEnable),
    .movcViolation(movcViolation)
  );

  pmem_fetch_dpath #(.DATA_W(DATA_W)) u_dpath (
    .strobes(strobes), .ramData(ramData), .romData(romData),
    .extData(extData), .extStrobeEn(extStrobeEn), .readData(readData)
  );

  assign selCodeRam  = strobes.selRam;
  assign selBootRom  = strobes.selRom;
  assign selExternal = strobes.selExt;

  p_strobe_ext_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    extStrobeEn |-> selExternal && !selCodeRam && !selBootRom);
endmodule

// File: tb/pmem_fetch_map_tb.sv
module pmem_fetch_map_tb;
  logic clk = 0, rstN = 0, strap = 0, bootEnWr = 0, bootEnWrData = 0;
  logic secLevel2 = 0, fetchValid = 0, isMovc = 0, execFromInternal = 0;
  logic [15:0] fetchAddr = '0;
  logic [7:0] ramData = 8'hA1, romData = 8'hB2, extData = 8'hC3;
  logic selCodeRam, selBootRom, selExternal, extStrobeEn, bootEnable, movcViolation;
  logic [15:0] resetVector;
  logic [7:0] readData;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmem_fetch_map u_dut (
    .clk(clk), .rstN(rstN), .extAccessStrap(strap), .bootEnWr(bootEnWr),
    .bootEnWrData(bootEnWrData), .secLevel2(secLevel2), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .isMovc(isMovc), .execFromInternal(execFromInternal),
    .ramData(ramData), .romData(romData), .extData(extData),
    .selCodeRam(selCodeRam), .selBootRom(selBootRom), .selExternal(selExternal),
    .extStrobeEn(extStrobeEn), .resetVector(resetVector), .readData(readData),
    .bootEnable(bootEnable), .movcViolation(movcViolation)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // selects packed as {ram, rom, ext, strobeEn}
  function automatic logic [15:0] sels();
    return {12'd0, selCodeRam, selBootRom, selExternal, extStrobeEn};
  endfunction

  task automatic doReset(logic s);
    @(negedge clk);
    rstN = 0; strap = s; fetchValid = 0; isMovc = 0; secLevel2 = 0;
    execFromInternal = 0; bootEnWr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
  endtask

  task automatic fetch(logic [15:0] a);
    fetchAddr = a; fetchValid = 1; #1;
  endtask

  task automatic t_strap_low;
    doReset(0);
    check("R1 vector", resetVector, 16'h0000);
    fetch(16'h0000); check("R1 sel lo", sels(), 16'h3); check("R11 ext data", {8'h0, readData}, 16'h00C3);
    fetch(16'hFFFF); check("R1 sel hi", sels(), 16'h3);
    fetchValid = 0; #1; check("R8 idle", sels(), 16'h0); check("R11 idle data", {8'h0, readData}, 16'h0);
  endtask

  task automatic t_strap_high;
    doReset(1);
    check("R6 vector", resetVector, 16'hF800);
    check("R5 boot reset", {15'd0, bootEnable}, 16'h1);
    fetch(16'h7FFF); check("R2 ram 7FFF", sels(), 16'h8); check("R11 ram data", {8'h0, readData}, 16'h00A1);
    fetch(16'h8000); check("R3 rom 8000", sels(), 16'h4); check("R11 rom data", {8'h0, readData}, 16'h00B2);
    fetchAddr = 16'h0123; #1; check("R12 same cycle", sels(), 16'h8);
    // R5 write boot enable to 0
    @(negedge clk); bootEnWr = 1; bootEnWrData = 0;
    @(negedge clk); bootEnWr = 0; #1;
    check("R5 boot write", {15'd0, bootEnable}, 16'h0);
    fetch(16'h8000); check("R4 ext 8000", sels(), 16'h3);
    fetch(16'h7FFF); check("R4 ram still", sels(), 16'h8);
    @(negedge clk); bootEnWr = 1; bootEnWrData = 1;
    @(negedge clk); bootEnWr = 0; fetch(16'hF800);
    check("R5 boot rewrite", sels(), 16'h4);
  endtask

  task automatic t_strap_change;
    doReset(1);
    @(negedge clk); strap = 0;
    repeat (2) @(negedge clk); #1;
    check("R7 vector kept", resetVector, 16'hF800);
    fetch(16'h1000); check("R7 decode kept", sels(), 16'h8);
    strap = 1;
  endtask

  task automatic t_security;
    doReset(1);
    secLevel2 = 1; isMovc = 1; execFromInternal = 1;
    fetch(16'h2000); check("R11 internal movc", {8'h0, readData}, 16'h00A1);
    secLevel2 = 0; execFromInternal = 0; #1;
    check("R11 no security", {8'h0, readData}, 16'h00A1);
    @(negedge clk); #1; check("R10 no flag", {15'd0, movcViolation}, 16'h0);
    secLevel2 = 1; #1;
    check("R9 ram blocked data", {8'h0, readData}, 16'h0000);
    check("R9 ram blocked sel", sels(), 16'h0);
    @(negedge clk); fetchValid = 0; isMovc = 0; #1;
    check("R10 flag set", {15'd0, movcViolation}, 16'h1);
    repeat (3) @(negedge clk); #1;
    check("R10 flag sticky", {15'd0, movcViolation}, 16'h1);
    isMovc = 1; fetch(16'hF900);
    check("R9 rom blocked", {8'h0, readData}, 16'h0000);
    // external target not blocked
    @(negedge clk); bootEnWr = 1; bootEnWrData = 0;
    @(negedge clk); bootEnWr = 0; fetch(16'hF900);
    check("R9 ext not blocked", {8'h0, readData}, 16'h00C3);
    fetchValid = 0; isMovc = 0;
    doReset(1);
    check("R10 reset clears", {15'd0, movcViolation}, 16'h0);
  endtask

  initial begin
    t_strap_low();
    t_strap_high();
    t_strap_change();
    t_security();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule